// File: doc/BRIEF.md
# SDRAM Read Latency and Mask Pipeline

This block is the device-side data timing path of a single-data-rate SDRAM. A read-column command starts a burst. A small internal sequencer then steps through the burst columns. Each column is turned into a 16-bit word by a simple array model. That word goes through a delay line whose length equals the programmed CAS latency, and then drives the data bus. The two byte-mask bits act on reads with a fixed two-cycle delay, so a masked byte lane is released to high impedance. On writes the same mask bits act with no delay: the byte enables to the array drop in the cycle the mask is sampled.

Timing convention: an input sampled at rising edge k has an effect "N cycles later" when that effect is present during the clock cycle that ends at edge k+N. Expressed in registers, it is visible just after edge k+N-1.

The read stream is valid-only. A DRAM data bus cannot stall, so there is no ready and no back-pressure. A slot that is scheduled is driven in exactly its cycle. The write outputs follow the write inputs in the same cycle, also without a handshake. The configuration and the stop input are plain control pins.

Top module: `sdr_rd_dq_path`

## Requirements
- R1: Reset leaves `dq_rd_oe`, `dq_lane_oe` and `dq_rd_data` at zero and sets the latency to 3.
- R2: A read command with latency L (1, 2 or 3) drives its first word with `dq_rd_oe` high L cycles after the command edge.
- R3: One command yields 4 words on consecutive cycles. The columns advance by incrementing the low two bits modulo 4 and keeping the upper bits, so a start at 6 gives 6, 7, 4, 5.
- R4: The word for column c is {c[7:0] xor 8'h5A, c[7:0] xor 8'hC3}, with the high byte in bits 15:8.
- R5: A read mask bit sampled at edge j takes its lane out of `dq_lane_oe` and zeroes that byte of `dq_rd_data` 2 cycles later. `dq_rd_oe` stays high. Bit 0 of `dqm` covers bits 7:0 and bit 1 covers bits 15:8.
- R6: The write path has zero mask latency. `mem_wr_be` equals `wr_valid` ANDed with the inverse of `dqm` in the same cycle. `mem_wr_col` and `mem_wr_data` follow `wr_col` and `wr_data` in that cycle.
- R7: A stop without a command issues no further column. After it, the bus still carries L-1 words (2, 1 or 0).
- R8: A read command in the middle of a burst restarts the burst at the new column, and its words follow the earlier ones in slot order. A command together with a stop counts as a command.
- R9: In every cycle with no scheduled word, `dq_rd_oe` and `dq_lane_oe` are low and `dq_rd_data` is zero.
- R10: `cfg_cas_lat` is taken only on an edge with no command, no burst in progress and no word in the delay line. Code 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cas_lat | input | 2 | Requested read latency, 1 to 3 (0 ignored) |
| rd_cmd_valid | input | 1 | Read-column command |
| rd_col | input | 9 | Start column of the burst |
| rd_stop | input | 1 | Burst stop or precharge interrupt |
| dqm | input | 2 | Byte mask, bit 0 low byte |
| wr_valid | input | 1 | Write word present |
| wr_col | input | 9 | Write column |
| wr_data | input | 16 | Write word |
| dq_rd_data | output | 16 | Read word on the bus, masked bytes zero |
| dq_rd_oe | output | 1 | A read slot is being driven |
| dq_lane_oe | output | 2 | Per-byte drive enable |
| mem_wr_col | output | 9 | Column to the array |
| mem_wr_data | output | 16 | Word to the array |
| mem_wr_be | output | 2 | Byte write enables to the array |

## Verification
Each issued read word is due exactly L cycles after the edge at which it was issued. Its lane enables depend on the mask sampled at the edge 2 cycles before the slot is compared. Write enables are due in the same cycle as their inputs. The driver records the edge number of every issued word and pushes the word with its due cycle into a queue. It also logs the mask for each edge. The monitor samples on the falling edge and pops the entry whose due cycle equals the current edge count. It rebuilds the lanes from the mask logged one edge earlier, and requires an idle bus in every other cycle. Write outputs are compared 1 ns after the inputs change.

// File: rtl/sdr_rdpath_pkg.sv
package sdr_rdpath_pkg;
  localparam int COL_W         = 9;
  localparam int DATA_W        = 16;
  localparam int LANES         = 2;
  localparam int BYTE_W        = DATA_W / LANES;
  localparam int DEF_MAX_CL    = 3;
  localparam int DEF_BURST_LEN = 4;

  // Array stand-in: a fixed function of the column address.
  function automatic logic [DATA_W-1:0] word_of(input logic [COL_W-1:0] col);
    return {col[7:0] ^ 8'h5A, col[7:0] ^ 8'hC3};
  endfunction
endpackage

// File: rtl/sdr_rd_burst_seq.sv
module sdr_rd_burst_seq
  import sdr_rdpath_pkg::*;
#(
  parameter int BURST_LEN = DEF_BURST_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cmd,
  input  logic [COL_W-1:0] rd_col,
  input  logic             rd_stop,
  output logic             col_v,
  output logic [COL_W-1:0] col,
  output logic             active
);
  localparam int LB = $clog2(BURST_LEN);
  localparam int CW = $clog2(BURST_LEN + 1);

  logic [COL_W-1:0] col_q;
  logic [CW-1:0]    left_q;

  // Sequential order, wrapping inside the burst-aligned group.
  function automatic logic [COL_W-1:0] step(input logic [COL_W-1:0] c);
    logic [COL_W-1:0] n;
    n         = c;
    n[LB-1:0] = c[LB-1:0] + 1'b1;
    return n;
  endfunction

  always_comb begin
    col_v = rd_cmd | (active & ~rd_stop);
    col   = rd_cmd ? rd_col : col_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      col_q  <= '0;
      left_q <= '0;
    end else if (rd_cmd) begin
      active <= (BURST_LEN > 1);
      col_q  <= step(rd_col);
      left_q <= CW'(BURST_LEN - 1);
    end else if (active) begin
      if (rd_stop) begin
        active <= 1'b0;
      end else begin
        col_q  <= step(col_q);
        left_q <= left_q - 1'b1;
        active <= (left_q != CW'(1));
      end
    end
  end

  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stop && !rd_cmd) |=> (col_v == rd_cmd));

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (left_q != '0));
endmodule

// File: rtl/sdr_rd_lat_pipe.sv
module sdr_rd_lat_pipe #(
  parameter int MAX_CL = 3,
  parameter int W      = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cl,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  output logic         v_out,
  output logic [W-1:0] d_out,
  output logic         any_v
);
  logic         sv [MAX_CL];
  logic [W-1:0] sd [MAX_CL];
  int           inj;

  // Entry stage chosen so that exactly cl registers lie on the path.
  always_comb inj = MAX_CL - int'(cl);

  for (genvar s = 0; s < MAX_CL; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sv[s] <= 1'b0;
          sd[s] <= '0;
        end else if (inj == s) begin
          sv[s] <= v_in;
          sd[s] <= d_in;
        end else begin
          sv[s] <= 1'b0;
          sd[s] <= '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sv[s] <= 1'b0;
          sd[s] <= '0;
        end else if (inj == s) begin
          sv[s] <= v_in;
          sd[s] <= d_in;
        end else begin
          sv[s] <= sv[s-1];
          sd[s] <= sd[s-1];
        end
      end
    end
  end

  always_comb begin
    any_v = 1'b0;
    for (int s = 0; s < MAX_CL; s++) any_v = any_v | sv[s];
    v_out = sv[MAX_CL-1];
    d_out = sd[MAX_CL-1];
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R2
  lat1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && v_out && cl == 2'd1) |-> $past(v_in, 1));
  // R2
  lat2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && v_out && cl == 2'd2) |-> $past(v_in, 2));
  // R2
  lat3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd3 && v_out && cl == 2'd3) |-> $past(v_in, 3));
endmodule

// File: rtl/sdr_rd_mask_pipe.sv
module sdr_rd_mask_pipe #(
  parameter int DEPTH = 2,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] m_in,
  output logic [LANES-1:0] m_out
);
  logic [LANES-1:0] q [DEPTH];

  for (genvar d = 0; d < DEPTH; d++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[d] <= '0;
      else if (d == 0) q[d] <= m_in;
      else            q[d] <= q[(d == 0) ? 0 : d-1];
    end
  end

  assign m_out = q[DEPTH-1];
endmodule

// File: rtl/sdr_rd_dq_path.sv
module sdr_rd_dq_path
  import sdr_rdpath_pkg::*;
#(
  parameter int BURST_LEN = DEF_BURST_LEN,
  parameter int MAX_CL    = DEF_MAX_CL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_cas_lat,
  input  logic              rd_cmd_valid,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              rd_stop,
  input  logic [LANES-1:0]  dqm,
  input  logic              wr_valid,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dq_rd_data,
  output logic              dq_rd_oe,
  output logic [LANES-1:0]  dq_lane_oe,
  output logic [COL_W-1:0]  mem_wr_col,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [LANES-1:0]  mem_wr_be
);
  localparam int RD_MASK_LAT = 2;

  logic [1:0]        cl_q;
  logic              col_v, seq_act, pipe_any, busy;
  logic [COL_W-1:0]  col;
  logic [DATA_W-1:0] pipe_d;
  logic [LANES-1:0]  rd_mask;

  sdr_rd_burst_seq #(.BURST_LEN(BURST_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd_valid), .rd_col(rd_col),
    .rd_stop(rd_stop), .col_v(col_v), .col(col), .active(seq_act));

  sdr_rd_lat_pipe #(.MAX_CL(MAX_CL), .W(DATA_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .cl(cl_q), .v_in(col_v), .d_in(word_of(col)),
    .v_out(dq_rd_oe), .d_out(pipe_d), .any_v(pipe_any));

  sdr_rd_mask_pipe #(.DEPTH(RD_MASK_LAT), .LANES(LANES)) u_mask (
    .clk(clk), .rst_n(rst_n), .m_in(dqm), .m_out(rd_mask));

  // Latency setting moves only while nothing is in flight.
  assign busy = rd_cmd_valid | seq_act | pipe_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cl_q <= 2'(MAX_CL);
    else if (!busy && cfg_cas_lat != 2'd0 && int'(cfg_cas_lat) <= MAX_CL)
      cl_q <= cfg_cas_lat;
  end

  assign dq_lane_oe = {LANES{dq_rd_oe}} & ~rd_mask;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_rd_data[g*BYTE_W +: BYTE_W] =
      dq_lane_oe[g] ? pipe_d[g*BYTE_W +: BYTE_W] : '0;
  end

  // Write side: mask acts in the same cycle.
  assign mem_wr_col  = wr_col;
  assign mem_wr_data = wr_data;
  assign mem_wr_be   = {LANES{wr_valid}} & ~dqm;

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cl_q == $past(cl_q)));

  // R10
  cfg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cas_lat == 2'd0) |=> (cl_q == $past(cl_q)));

  for (genvar g = 0; g < LANES; g++) begin : g_mchk
    // R5
    rd_mask_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && dq_lane_oe[g]) |-> !$past(dqm[g], 2));
  end

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_rd_oe |-> (dq_lane_oe == '0 && dq_rd_data == '0));
endmodule

// File: tb/sdr_rd_dq_path_bench.sv
module sdr_rd_dq_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_cas_lat = 2'd0;
  logic        rd_cmd_valid = 1'b0;
  logic [8:0]  rd_col = '0;
  logic        rd_stop = 1'b0;
  logic [1:0]  dqm = '0;
  logic        wr_valid = 1'b0;
  logic [8:0]  wr_col = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] dq_rd_data;
  logic        dq_rd_oe;
  logic [1:0]  dq_lane_oe;
  logic [8:0]  mem_wr_col;
  logic [15:0] mem_wr_data;
  logic [1:0]  mem_wr_be;

  sdr_rd_dq_path u_sdr_rd_dq_path (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat),
    .rd_cmd_valid(rd_cmd_valid), .rd_col(rd_col), .rd_stop(rd_stop),
    .dqm(dqm), .wr_valid(wr_valid), .wr_col(wr_col), .wr_data(wr_data),
    .dq_rd_data(dq_rd_data), .dq_rd_oe(dq_rd_oe), .dq_lane_oe(dq_lane_oe),
    .mem_wr_col(mem_wr_col), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be));

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0, run = 0;
  logic [1:0] dh [0:4095];
  int         qdue [$];
  logic [15:0] qword [$];

  // Reference model state
  bit         m_act = 0;
  logic [8:0] m_col = '0;
  int         m_left = 0;
  int         m_cl = 3;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] exp_word(input logic [8:0] c);  // R4
    return {c[7:0] ^ 8'h5A, c[7:0] ^ 8'hC3};
  endfunction

  function automatic logic [8:0] nxt(input logic [8:0] c);  // R3
    return {c[8:2], 2'(c[1:0] + 2'd1)};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic tick(input bit cmd, input logic [8:0] col, input bit stop,
                      input logic [1:0] dq, input bit wv,
                      input logic [8:0] wc, input logic [15:0] wd);
    bit iss;
    logic [8:0] icol;
    rd_cmd_valid = cmd; rd_col = col; rd_stop = stop; dqm = dq;
    wr_valid = wv; wr_col = wc; wr_data = wd;
    dh[cyc+1] = dq;
    iss  = cmd || (m_act && !stop);
    icol = cmd ? col : m_col;
    if (iss) begin
      qdue.push_back(cyc + m_cl);
      qword.push_back(exp_word(icol));
    end
    if (cmd) begin
      m_act = 1; m_col = nxt(col); m_left = 3;
    end else if (m_act) begin
      if (stop) m_act = 0;
      else begin
        m_col = nxt(m_col); m_left--; if (m_left == 0) m_act = 0;
      end
    end
    #1;
    n_vec++;  // R6: write enables and pass-through in the same cycle
    if (mem_wr_be != ({2{wv}} & ~dq) || mem_wr_col != wc || mem_wr_data != wd) begin
      n_bad++;
      $display("FAIL R6 be=%b col=%h data=%h exp be=%b col=%h data=%h",
               mem_wr_be, mem_wr_col, mem_wr_data, {2{wv}} & ~dq, wc, wd);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, '0, 0, 2'b00, 0, '0, '0);
  endtask

  // Monitor: compares the bus against the scoreboard each falling edge.
  always @(negedge clk) begin
    if (run) begin
      logic [1:0]  lanes;
      logic [15:0] w, ed;
      n_vec++;
      if (qdue.size() > 0 && qdue[0] == cyc) begin
        void'(qdue.pop_front());
        w = qword.pop_front();
        lanes = ~dh[cyc-1];
        ed = {lanes[1] ? w[15:8] : 8'h00, lanes[0] ? w[7:0] : 8'h00};
        if (!dq_rd_oe || dq_lane_oe != lanes || dq_rd_data != ed) begin
          n_bad++;
          $display("FAIL R2/R5 cyc=%0d oe=%b lanes=%b data=%h exp oe=1 lanes=%b data=%h",
                   cyc, dq_rd_oe, dq_lane_oe, dq_rd_data, lanes, ed);
        end
      end else if (dq_rd_oe || dq_lane_oe != 2'b00 || dq_rd_data != 16'h0) begin
        n_bad++;
        $display("FAIL R9 cyc=%0d oe=%b lanes=%b data=%h exp oe=0 lanes=00 data=0000",
                 cyc, dq_rd_oe, dq_lane_oe, dq_rd_data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) dh[i] = 2'b00;
    repeat (3) @(negedge clk);
    n_vec++;  // R1: bus idle in reset
    if (dq_rd_oe || dq_lane_oe != 2'b00 || dq_rd_data != 16'h0) begin
      n_bad++;
      $display("FAIL R1 oe=%b lanes=%b data=%h exp 0/00/0000", dq_rd_oe, dq_lane_oe, dq_rd_data);
    end
    rst_n = 1'b1;
    run = 1;
    idle(2);

    // R1 default latency 3 (cfg held at 0), R3 wrap 6,7,4,5, R4 words
    m_cl = 3;
    tick(1, 9'h006, 0, 2'b00, 0, '0, '0);
    idle(7);

    // R2 latency 2 with R5 mask pattern across the burst
    cfg_cas_lat = 2'd2; idle(2); m_cl = 2;
    tick(1, 9'h010, 0, 2'b01, 0, '0, '0);
    tick(0, '0, 0, 2'b10, 1, 9'h011, 16'hBEEF);
    tick(0, '0, 0, 2'b11, 1, 9'h012, 16'h1234);
    tick(0, '0, 0, 2'b00, 0, '0, '0);
    tick(0, '0, 0, 2'b10, 0, '0, '0);
    idle(5);

    // R8 restart mid-burst, command wins over simultaneous stop
    tick(1, 9'h008, 0, 2'b00, 0, '0, '0);
    tick(0, '0, 0, 2'b00, 0, '0, '0);
    tick(1, 9'h130, 1, 2'b00, 1, 9'h1FF, 16'hA55A);
    idle(7);

    // R2 latency 1, R7 stop after two words (0 extra words)
    cfg_cas_lat = 2'd1; idle(2); m_cl = 1;
    tick(1, 9'h021, 0, 2'b00, 0, '0, '0);
    tick(0, '0, 0, 2'b01, 0, '0, '0);
    tick(0, '0, 1, 2'b00, 0, '0, '0);
    idle(4);

    // R2 latency 3, R7 stop: two more words after it
    cfg_cas_lat = 2'd3; idle(2); m_cl = 3;
    tick(1, 9'h050, 0, 2'b00, 0, '0, '0);
    tick(0, '0, 0, 2'b00, 0, '0, '0);
    tick(0, '0, 1, 2'b00, 0, '0, '0);
    idle(6);

    // R10 change while busy is held off until the pipe drains
    tick(1, 9'h040, 0, 2'b00, 0, '0, '0);
    cfg_cas_lat = 2'd1;
    tick(0, '0, 0, 2'b00, 0, '0, '0);
    tick(0, '0, 0, 2'b00, 0, '0, '0);
    tick(0, '0, 0, 2'b00, 0, '0, '0);
    idle(6);
    m_cl = 1;
    tick(1, 9'h044, 0, 2'b00, 0, '0, '0);
    idle(5);

    // R10 code 0 leaves latency 1 in place
    cfg_cas_lat = 2'd0; idle(3);
    tick(1, 9'h0F7, 0, 2'b00, 0, '0, '0);
    idle(6);

    n_vec++;  // R2: every scheduled word was seen
    if (qdue.size() != 0) begin
      n_bad++;
      $display("FAIL R2 pending=%0d exp 0", qdue.size());
    end
    run = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule